// File: doc/BRIEF.md
# Timer-clocked serial port

This block is an asynchronous serial transmitter and receiver for a small microcontroller core. Its bit clock comes from outside: each overflow pulse of an 8-bit auto-reload timer arrives as a one-cycle `baudTick`, and one bit time spans 32 such pulses. The reload value of that timer therefore sets the line rate.

The core reaches the port at two addresses. Address 0 is a packed control byte holding the framing mode, the receive enable, the captured stop bit and the two done flags. Address 1 is a shared data buffer. Writing address 1 starts a transmission. Reading address 1 returns the last byte received, never the byte being sent.

Frames have one low start bit, eight data bits sent least significant first, and one high stop bit. The receiver takes three samples near the middle of each bit and keeps the majority value. The two done flags are also driven straight out to the interrupt logic.

Top module: `timer_uart`

## Requirements
- R1: After reset `serOut` is high, both done outputs are low and the control byte (address 0) reads 00h.
- R2: A write to address 1 while the transmitter is idle sends a frame on `serOut`: a low start bit, the eight data bits with the least significant bit first, then a high stop bit. Every data and stop bit lasts exactly 32 `baudTick` pulses. The line stays high whenever no frame is in progress.
- R3: When `baudTick` pulses once every 36 clock cycles (reload FDh, 12 clocks per timer count), one bit lasts 1152 clocks. At 11.0592 MHz that is 9600 bit/s.
- R4: The transmit-done flag (control bit 1) rises only once the stop bit has finished. It is still low in the middle of the stop bit.
- R5: A write to address 1 during a transmission is ignored. The frame in progress is unchanged and no second frame follows.
- R6: With receive enable (control bit 4) set, a complete incoming frame sets the receive-done flag (control bit 0). The byte can then be read at address 1, and the value sampled in the middle of the stop bit appears in control bit 2.
- R7: Each received bit is the majority of three samples taken near mid-bit, so a disturbance covering one sample does not corrupt the byte.
- R8: A start bit that reads high at its middle is rejected as a false start. No flag is set, and the receiver accepts the next frame normally.
- R9: With receive enable clear, incoming frames are ignored. The flag, the buffer and control bit 2 keep their values.
- R10: If the receive-done flag is still set when a stop bit is sampled, that byte is discarded. The buffer and control bit 2 keep their old contents.
- R11: Software cannot set either done flag. Writing 1 to bits 1:0 has no effect, and writing 0 clears them. A hardware set in the same cycle as a software clear leaves the flag set.
- R12: Control bits 7:3 read back as written. Control bit 2 is changed only by reception.
- R13: `txDoneIrq` and `rxDoneIrq` always equal control bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle timer overflow pulse |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 selects the control byte, 1 the data buffer |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the selected address (combinational) |
| serOut | output | 1 | Serial transmit line |
| serIn | input | 1 | Serial receive line (asynchronous) |
| txDoneIrq | output | 1 | Transmit-done flag to the interrupt logic |
| rxDoneIrq | output | 1 | Receive-done flag to the interrupt logic |

## Verification
The transmit-done and receive-done flags can be raised in the same cycle, and either can meet a software clear in that cycle. The bench provokes the first case by starting a transmission and an incoming frame at the same moment with the same bit period, so both complete within a few cycles of each other. It then judges both bytes, both flags, and that the buffer still shows the received byte. The priority of a hardware set over a software clear is guarded by a property beside the flag logic.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int BYTE_W = 8;

  // Strobes from the sequencing logic to the datapath
  typedef struct packed {
    logic txLoad;    // capture a new byte into the transmit frame
    logic txShift;   // advance the transmit frame by one bit
    logic txEnd;     // last bit of the frame has finished
    logic rxSample;  // record one early mid-bit sample
    logic rxShift;   // push the voted data bit into the receive shifter
    logic rxStop;    // stop bit voted: commit the byte unless a byte is pending
  } serStrobe_t;
endpackage

// File: rtl/ser_control.sv
module ser_control
  import ser_pkg::*;
#(
  parameter int TICKS_PER_BIT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       bufWr,
  input  logic       rxLine,
  input  logic       rxMaj,
  input  logic       rxEnable,
  output serStrobe_t strb,
  output logic       txBusy
);
  localparam int CNT_W      = $clog2(TICKS_PER_BIT);
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID    = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] SAMP_A = CNT_W'(TICKS_PER_BIT / 2 - 3);
  localparam logic [CNT_W-1:0] SAMP_B = CNT_W'(TICKS_PER_BIT / 2 - 2);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  // ---------------- transmit sequencing ----------------
  logic [CNT_W-1:0] txCnt;
  logic [IDX_W-1:0] txIdx;
  logic             txBitEnd;

  assign txBitEnd = txBusy && tick && (txCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (!txBusy) begin
      if (bufWr) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
        txIdx  <= '0;
      end
    end else if (tick) begin
      if (txCnt == LAST) begin
        txCnt <= '0;
        if (txIdx == IDX_W'(FRAME_BITS - 1)) txBusy <= 1'b0;
        else                                 txIdx  <= txIdx + 1'b1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  rxState_t         rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] rxIdx;
  logic             rxOn;
  logic             rxDecide;

  assign rxOn     = (rxState != RX_IDLE);
  assign rxDecide = rxOn && tick && (rxCnt == MID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else if (rxState == RX_IDLE) begin
      if (rxEnable && !rxLine) begin
        rxState <= RX_START;
        rxCnt   <= '0;
        rxIdx   <= '0;
      end
    end else if (tick) begin
      rxCnt <= (rxCnt == LAST) ? '0 : rxCnt + 1'b1;
      if (rxState == RX_START && rxCnt == MID && rxMaj) begin
        rxState <= RX_IDLE;                    // false start
      end else if (rxState == RX_STOP && rxCnt == MID) begin
        rxState <= RX_IDLE;
      end else if (rxCnt == LAST) begin
        if (rxState == RX_START) begin
          rxState <= RX_DATA;
        end else if (rxState == RX_DATA) begin
          if (rxIdx == IDX_W'(BYTE_W - 1)) rxState <= RX_STOP;
          else                             rxIdx   <= rxIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.txLoad   = !txBusy && bufWr;
    strb.txShift  = txBitEnd;
    strb.txEnd    = txBitEnd && (txIdx == IDX_W'(FRAME_BITS - 1));
    strb.rxSample = rxOn && tick && (rxCnt == SAMP_A || rxCnt == SAMP_B);
    strb.rxShift  = rxDecide && (rxState == RX_DATA);
    strb.rxStop   = rxDecide && (rxState == RX_STOP);
  end

  // R9: with reception disabled an idle receiver never leaves idle
  p_rx_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && !rxEnable) |=> (rxState == RX_IDLE));

  // R5: a load is never issued on the cycle after one was accepted
  p_no_back_to_back_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !strb.txLoad);
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  input  logic              ctrlWr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              serIn,
  output logic              txLine,
  output logic              rxLine,
  output logic              rxMaj,
  output logic              rxEnable,
  output logic              tiFlag,
  output logic              riFlag,
  output logic [7:0]        ctrlByte,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int HI_W       = 5;          // control bits 7:3
  localparam int REN_POS    = 4 - 3;      // receive enable inside the upper field

  logic [SYNC_STAGES-1:0] syncReg;
  logic [HI_W-1:0]        ctrlHi;
  logic                   rb8;
  logic [FRAME_BITS-1:0]  txFrame;
  logic [BYTE_W-1:0]      rxShiftReg;
  logic [1:0]             sampHist;

  // input synchronizer, depth set by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= serIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], serIn};
      end
    end
  endgenerate

  assign rxLine   = syncReg[SYNC_STAGES-1];
  assign rxMaj    = (sampHist[1] & sampHist[0]) | (sampHist[1] & rxLine) |
                    (sampHist[0] & rxLine);
  assign rxEnable = ctrlHi[REN_POS];
  assign txLine   = txFrame[0];
  assign ctrlByte = {ctrlHi, rb8, tiFlag, riFlag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlHi     <= '0;
      rb8        <= 1'b0;
      tiFlag     <= 1'b0;
      riFlag     <= 1'b0;
      txFrame    <= '1;
      rxShiftReg <= '0;
      rxByte     <= '0;
      sampHist   <= '1;
    end else begin
      if (ctrlWr) ctrlHi <= wrData[7:3];

      if (strb.txLoad)       txFrame <= {1'b1, wrData, 1'b0};
      else if (strb.txShift) txFrame <= {1'b1, txFrame[FRAME_BITS-1:1]};

      if (strb.rxSample) sampHist   <= {sampHist[0], rxLine};
      if (strb.rxShift)  rxShiftReg <= {rxMaj, rxShiftReg[BYTE_W-1:1]};

      if (strb.rxStop && !riFlag) begin
        rxByte <= rxShiftReg;
        rb8    <= rxMaj;
      end

      // hardware set takes priority over a software clear
      if (strb.txEnd)                tiFlag <= 1'b1;
      else if (ctrlWr && !wrData[1]) tiFlag <= 1'b0;

      if (strb.rxStop && !riFlag)    riFlag <= 1'b1;
      else if (ctrlWr && !wrData[0]) riFlag <= 1'b0;
    end
  end

  // R4 / R11: the end of a frame always leaves the transmit flag set
  p_ti_set_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.txEnd |=> tiFlag);

  // R10: a pending byte is never overwritten by a later stop bit
  p_pending_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxStop && riFlag) |=> ($stable(rxByte) && $stable(rb8)));

  // R11: a control write alone cannot raise the receive flag
  p_sw_cannot_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !strb.rxStop && !riFlag) |=> !riFlag);

  // R5: a new byte is accepted only while the line rests high
  p_load_on_idle_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |-> txLine);
endmodule

// File: rtl/timer_uart.sv
module timer_uart
  import ser_pkg::*;
#(
  parameter int TICKS_PER_BIT = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       busWrEn,
  input  logic       busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       serOut,
  input  logic       serIn,
  output logic       txDoneIrq,
  output logic       rxDoneIrq
);
  serStrobe_t        strb;
  logic              txBusy;
  logic              rxLine;
  logic              rxMaj;
  logic              rxEnable;
  logic [7:0]        ctrlByte;
  logic [BYTE_W-1:0] rxByte;
  logic              ctrlWr;
  logic              bufWr;

  assign ctrlWr = busWrEn && !busAddr;
  assign bufWr  = busWrEn &&  busAddr;

  ser_control #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (baudTick),
    .bufWr    (bufWr),
    .rxLine   (rxLine),
    .rxMaj    (rxMaj),
    .rxEnable (rxEnable),
    .strb     (strb),
    .txBusy   (txBusy)
  );

  ser_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ctrlWr   (ctrlWr),
    .wrData   (busWrData),
    .serIn    (serIn),
    .txLine   (serOut),
    .rxLine   (rxLine),
    .rxMaj    (rxMaj),
    .rxEnable (rxEnable),
    .tiFlag   (txDoneIrq),
    .riFlag   (rxDoneIrq),
    .ctrlByte (ctrlByte),
    .rxByte   (rxByte)
  );

  assign busRdData = busAddr ? rxByte : ctrlByte;

  // R2: the line rests high whenever the transmitter is not busy
  p_line_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> serOut);
endmodule

// File: tb/timer_uart_bench.sv
module timer_uart_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       serOut;
  logic       serIn = 1'b1;
  logic       txDoneIrq;
  logic       rxDoneIrq;

  int nTests = 0;
  int nFail  = 0;
  int tickPeriod = 4;

  logic [7:0] capByte;
  logic       capStop;
  logic       capTiMid;

  timer_uart u_timer_uart (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .serOut(serOut), .serIn(serIn), .txDoneIrq(txDoneIrq), .rxDoneIrq(rxDoneIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // timer overflow pulses, one every tickPeriod clocks
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt >= tickPeriod - 1) begin baudTick <= 1'b1; cnt = 0; end
      else begin baudTick <= 1'b0; cnt++; end
    end
  end

  // ---------------- reference functions ----------------
  function automatic int bitClocks(int reload, int clkPerCount);
    return (256 - reload) * clkPerCount * 32;
  endfunction

  function automatic logic [7:0] expCtrl(logic [7:0] wr, logic rb8, logic ti, logic ri);
    return (wr & 8'hF8) | {5'b0, rb8, ti, ri};
  endfunction

  // ---------------- helpers ----------------
  task automatic checkEq(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic a, logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame on serIn; glitchBit >= 0 flips one data bit for one tick near mid-bit
  task automatic sendFrame(logic [7:0] d, logic stopVal, int glitchBit);
    int bc = tickPeriod * 32;
    int pre = 14 * tickPeriod + tickPeriod / 2;
    @(negedge clk);
    serIn = 1'b0;
    waitClk(bc);
    for (int i = 0; i < 8; i++) begin
      serIn = d[i];
      if (i == glitchBit) begin
        waitClk(pre);
        serIn = ~d[i];
        waitClk(tickPeriod);
        serIn = d[i];
        waitClk(bc - pre - tickPeriod);
      end else begin
        waitClk(bc);
      end
    end
    serIn = stopVal;
    waitClk(bc);
    serIn = 1'b1;
  endtask

  // decode one frame from serOut by mid-bit sampling
  task automatic captureTx();
    int bc = tickPeriod * 32;
    int n = 0;
    while (serOut && n < 5 * bc) begin @(negedge clk); n++; end
    waitClk(bc / 2);
    for (int i = 0; i < 8; i++) begin
      waitClk(bc);
      capByte[i] = serOut;
    end
    waitClk(bc);
    capStop  = serOut;
    capTiMid = txDoneIrq;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] rd, d, d2, prevBuf;
    int bc, lows, hiCnt, loCnt;
    void'($urandom(32'd2024));

    waitClk(5);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset state
    checkEq("R1", "serOut", serOut, 1);
    checkEq("R1", "txDoneIrq", txDoneIrq, 0);
    checkEq("R1", "rxDoneIrq", rxDoneIrq, 0);
    busRead(1'b0, rd);
    checkEq("R1", "control", rd, 8'h00);

    // R12: upper control bits read back
    busWrite(1'b0, 8'h50);
    busRead(1'b0, rd);
    checkEq("R12", "control readback", rd, expCtrl(8'h50, 0, 0, 0));

    // R11: software cannot set the flags
    busWrite(1'b0, 8'h53);
    busRead(1'b0, rd);
    checkEq("R11", "flags after writing ones", rd, expCtrl(8'h53, 0, 0, 0));
    busWrite(1'b0, 8'h50);

    bc = tickPeriod * 32;

    // R2 / R4: random transmit bytes
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      busWrite(1'b1, d);
      captureTx();
      checkEq("R2", "tx data", capByte, d);
      checkEq("R2", "tx stop", capStop, 1);
      checkEq("R4", "ti at stop middle", capTiMid, 0);
      waitClk(bc);
      checkEq("R4", "ti after stop", txDoneIrq, 1);
      busRead(1'b0, rd);
      checkEq("R13", "ti mirrors bit 1", txDoneIrq, rd[1]);
      busWrite(1'b0, 8'h50);
      checkEq("R11", "ti cleared by zero", txDoneIrq, 0);
    end

    // R5: write during a transmission is ignored
    busWrite(1'b1, 8'hA5);
    fork
      captureTx();
      begin waitClk(3 * bc); busWrite(1'b1, 8'h3C); end
    join
    checkEq("R5", "frame unchanged", capByte, 8'hA5);
    waitClk(bc);
    lows = 0;
    for (int i = 0; i < 3 * bc; i++) begin
      @(negedge clk);
      if (!serOut) lows++;
    end
    checkEq("R5", "no second frame", lows, 0);
    busWrite(1'b0, 8'h50);

    // R6 / R13: random receive bytes
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      sendFrame(d, 1'b1, -1);
      waitClk(4);
      checkEq("R6", "ri set", rxDoneIrq, 1);
      busRead(1'b1, rd);
      checkEq("R6", "rx byte", rd, d);
      busRead(1'b0, rd);
      checkEq("R6", "control after rx", rd, expCtrl(8'h50, 1, 0, 1));
      checkEq("R13", "ri mirrors bit 0", rxDoneIrq, rd[0]);
      busWrite(1'b0, 8'h50);
      busRead(1'b0, rd);
      checkEq("R12", "rb8 kept by ctrl write", rd, expCtrl(8'h50, 1, 0, 0));
    end

    // R6: low stop bit captured into bit 2
    d = 8'($urandom);
    sendFrame(d, 1'b0, -1);
    busRead(1'b1, rd);
    checkEq("R6", "rx byte with low stop", rd, d);
    busRead(1'b0, rd);
    checkEq("R6", "rb8 low stop", rd, expCtrl(8'h50, 0, 0, 1));
    waitClk(12 * bc);
    busWrite(1'b0, 8'h50);

    // R10: overrun discards the second byte
    d = 8'h5A; d2 = 8'hC3;
    sendFrame(d, 1'b1, -1);
    sendFrame(d2, 1'b1, -1);
    waitClk(4);
    busRead(1'b1, rd);
    checkEq("R10", "buffer kept", rd, d);
    busRead(1'b0, rd);
    checkEq("R10", "flags/rb8 kept", rd, expCtrl(8'h50, 1, 0, 1));
    busWrite(1'b0, 8'h50);

    // R7: single-sample disturbance rejected by the vote
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      sendFrame(d, 1'b1, k * 3 + 1);
      waitClk(4);
      busRead(1'b1, rd);
      checkEq("R7", "byte with glitch", rd, d);
      busWrite(1'b0, 8'h50);
    end

    // R8: false start
    @(negedge clk);
    serIn = 1'b0;
    waitClk(6 * tickPeriod);
    serIn = 1'b1;
    waitClk(2 * bc);
    checkEq("R8", "no ri after false start", rxDoneIrq, 0);
    d = 8'h96;
    sendFrame(d, 1'b1, -1);
    waitClk(4);
    busRead(1'b1, rd);
    checkEq("R8", "next frame accepted", rd, d);
    busWrite(1'b0, 8'h50);

    // R9: reception disabled
    busRead(1'b1, prevBuf);
    busWrite(1'b0, 8'h40);
    sendFrame(8'h0F, 1'b1, -1);
    waitClk(4);
    checkEq("R9", "ri stays low", rxDoneIrq, 0);
    busRead(1'b1, rd);
    checkEq("R9", "buffer unchanged", rd, prevBuf);
    busWrite(1'b0, 8'h50);

    // full duplex: both completions land close together
    d = 8'h81; d2 = 8'h7E;
    busWrite(1'b1, d);
    fork
      captureTx();
      sendFrame(d2, 1'b1, -1);
    join
    waitClk(bc);
    checkEq("R2", "duplex tx byte", capByte, d);
    checkEq("R4", "duplex ti", txDoneIrq, 1);
    checkEq("R6", "duplex ri", rxDoneIrq, 1);
    busRead(1'b1, rd);
    checkEq("R12", "buffer shows received byte", rd, d2);
    busWrite(1'b0, 8'h50);

    // R3: bit rate with reload FDh
    tickPeriod = (256 - 8'hFD) * 12;
    waitClk(2 * tickPeriod);
    busWrite(1'b1, 8'h55);
    hiCnt = 0;
    while (!serOut) @(negedge clk);
    while (serOut) begin @(negedge clk); hiCnt++; end
    checkEq("R3", "bit length in clocks", hiCnt, bitClocks(8'hFD, 12));
    checkEq("R3", "bit rate", 11059200 / hiCnt, 9600);
    loCnt = 0;
    while (!serOut) begin @(negedge clk); loCnt++; end
    checkEq("R3", "next bit length", loCnt, bitClocks(8'hFD, 12));
    waitClk(10 * bitClocks(8'hFD, 12));
    checkEq("R4", "ti after slow frame", txDoneIrq, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule